// File: doc/BRIEF.md
# Six-Bit-Controlled Preset ALU

This block is a purely combinational 16-bit arithmetic and logic unit. It takes two operands, `a_i` and `b_i`, and six single-bit controls. There is no opcode table. Each operand first passes through its own clear stage and then its own complement stage. A core stage then forms either the two's-complement sum or the bitwise AND of the conditioned operands. A final stage can complement the core output. About twenty useful functions come from combining these controls, such as constants, pass-through, negation, increment, decrement, subtraction, AND and OR.

The adder is a ripple chain. A half adder sits at bit 0, and full adders sit above it, each passing its carry upward. The carry out of the top bit is dropped. Two flags are derived from the result: a zero flag and a negative flag. With the subtract setting, these flags compare the operands.

Top module: `preset_alu`

## Requirements
- R1: When `clr_a_i` is 1, the conditioned first operand is all zeros regardless of `a_i`.
- R2: When `neg_a_i` is 1, the conditioned first operand is complemented after the clear stage, so `clr_a_i`=1 together with `neg_a_i`=1 gives 16'hFFFF.
- R3: When `clr_b_i` is 1, the conditioned second operand is all zeros regardless of `b_i`.
- R4: When `neg_b_i` is 1, the conditioned second operand is complemented after the clear stage, so `clr_b_i`=1 together with `neg_b_i`=1 gives 16'hFFFF.
- R5: When `use_add_i` is 1, the core output is the sum of the conditioned operands modulo 2^16, and the carry out of bit 15 is discarded.
- R6: When `use_add_i` is 0, the core output is the bitwise AND of the conditioned operands.
- R7: When `neg_out_i` is 1, `result_o` is the bitwise complement of the core output; otherwise `result_o` equals the core output.
- R8: `is_zero_o` is 1 exactly when all 16 bits of `result_o` are 0.
- R9: `is_neg_o` equals bit 15 of `result_o`.
- R10: The subtract setting is {clr_a,neg_a,clr_b,neg_b,use_add,neg_out} = 010011. It gives `result_o` = a_i - b_i. When that difference does not overflow, a>b gives zero=0 and neg=0, a==b gives zero=1 and neg=0, and a<b gives zero=0 and neg=1.
- R11: When a_i - b_i overflows in 16-bit two's complement, the flags follow the wrapped difference, not the true signed order.
- R12: The block has no clock or state, and the outputs follow any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| clr_a_i | input | 1 | Clear first operand |
| neg_a_i | input | 1 | Complement first operand after clear |
| clr_b_i | input | 1 | Clear second operand |
| neg_b_i | input | 1 | Complement second operand after clear |
| use_add_i | input | 1 | 1 selects sum, 0 selects AND |
| neg_out_i | input | 1 | Complement core output |
| result_o | output | 16 | Final result |
| is_zero_o | output | 1 | Result is all zeros |
| is_neg_o | output | 1 | Result sign bit |

## Verification
The hardest situation to reach from the ports is a carry that ripples through all sixteen stages and then falls off the top. The bench forces it with 16'hFFFF plus 16'h0001 and by adding all-ones operands made by the clear-then-complement path. It must then see a zero or near-zero result rather than a truncated chain. The subtract setting is also driven with operands whose difference overflows, such as 16'h7FFF against 16'h8000. This shows that the sign flag follows the wrapped difference. Equality comparisons are made with identical non-zero operands, so that the zero flag comes from the arithmetic and not from zero inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 16;

  typedef struct packed {
    logic clr_a;
    logic neg_a;
    logic clr_b;
    logic neg_b;
    logic use_add;
    logic neg_out;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             clr_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] opnd_o
);
  logic [WIDTH-1:0] cleared;

  // clear stage first, complement stage second
  always_comb begin
    cleared = clr_i ? '0 : opnd_i;
    opnd_o  = neg_i ? ~cleared : cleared;
  end
endmodule

// File: rtl/alu_half_add.sv
module alu_half_add (
  input  logic p_i,
  input  logic q_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = p_i ^ q_i;
  assign c_o = p_i & q_i;
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic p_i,
  input  logic q_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic hs, hc0, hc1;

  alu_half_add i_ha0 (.p_i(p_i), .q_i(q_i), .s_o(hs),  .c_o(hc0));
  alu_half_add i_ha1 (.p_i(hs),  .q_i(c_i), .s_o(s_o), .c_o(hc1));
  assign c_o = hc0 | hc1;
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [TOP:0] carry;
  logic         unused_top_carry;

  alu_half_add i_bit0 (
    .p_i(p_i[0]), .q_i(q_i[0]), .s_o(sum_o[0]), .c_o(carry[0])
  );

  genvar k;
  generate
    for (k = 1; k < WIDTH; k++) begin : g_stage
      alu_full_add i_fa (
        .p_i(p_i[k]), .q_i(q_i[k]), .c_i(carry[k-1]),
        .s_o(sum_o[k]), .c_o(carry[k])
      );
    end
  endgenerate

  // carry out of the top stage is dropped
  assign unused_top_carry = carry[TOP];
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             neg_o
);
  assign zero_o = ~|res_i;
  assign neg_o  = res_i[WIDTH-1];
endmodule

// File: rtl/preset_alu.sv
module preset_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = ALU_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             clr_a_i,
  input  logic             neg_a_i,
  input  logic             clr_b_i,
  input  logic             neg_b_i,
  input  logic             use_add_i,
  input  logic             neg_out_i,
  output logic [WIDTH-1:0] result_o,
  output logic             is_zero_o,
  output logic             is_neg_o
);
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] a_cond, b_cond, sum, core;

  assign ctrl = '{clr_a: clr_a_i, neg_a: neg_a_i, clr_b: clr_b_i,
                  neg_b: neg_b_i, use_add: use_add_i, neg_out: neg_out_i};

  alu_operand_cond #(.WIDTH(WIDTH)) i_cond_a (
    .opnd_i(a_i), .clr_i(ctrl.clr_a), .neg_i(ctrl.neg_a), .opnd_o(a_cond)
  );
  alu_operand_cond #(.WIDTH(WIDTH)) i_cond_b (
    .opnd_i(b_i), .clr_i(ctrl.clr_b), .neg_i(ctrl.neg_b), .opnd_o(b_cond)
  );

  alu_ripple_add #(.WIDTH(WIDTH)) i_add (
    .p_i(a_cond), .q_i(b_cond), .sum_o(sum)
  );

  always_comb begin
    core     = ctrl.use_add ? sum : (a_cond & b_cond);
    result_o = ctrl.neg_out ? ~core : core;
  end

  alu_flags #(.WIDTH(WIDTH)) i_flags (
    .res_i(result_o), .zero_o(is_zero_o), .neg_o(is_neg_o)
  );
endmodule

// File: rtl/preset_alu_chk.sv
module preset_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             clr_a_i,
  input logic             neg_a_i,
  input logic             clr_b_i,
  input logic             neg_b_i,
  input logic             use_add_i,
  input logic             neg_out_i,
  input logic [WIDTH-1:0] result_o,
  input logic             is_zero_o,
  input logic             is_neg_o
);
  logic [5:0] sel;
  assign sel = {clr_a_i, neg_a_i, clr_b_i, neg_b_i, use_add_i, neg_out_i};

  always_comb begin
    if (sel == 6'b101000)
      AST_CLEAR_A_AND: assert (result_o == '0) else $error("clear a");          // R1
    if (sel == 6'b111100)
      AST_CLEAR_THEN_INV: assert (&result_o) else $error("clear then inv");     // R2
    if (sel == 6'b001100)
      AST_PASS_A: assert (result_o == a_i) else $error("pass a");               // R4
    if (sel == 6'b001010)
      AST_ADD_ZERO: assert (result_o == a_i) else $error("add zero");           // R5
    if (sel == 6'b010011)
      AST_SUBTRACT: assert (result_o == WIDTH'(a_i - b_i)) else $error("sub");  // R10
    AST_FLAGS_EXCL: assert (!(is_zero_o && is_neg_o)) else $error("flags");     // R8
  end
endmodule

bind preset_alu preset_alu_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i(a_i), .b_i(b_i), .clr_a_i(clr_a_i), .neg_a_i(neg_a_i),
  .clr_b_i(clr_b_i), .neg_b_i(neg_b_i), .use_add_i(use_add_i),
  .neg_out_i(neg_out_i), .result_o(result_o), .is_zero_o(is_zero_o),
  .is_neg_o(is_neg_o)
);

// File: tb/test_preset_alu.sv
`timescale 1ns/1ps
module test_preset_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a, b, res;
  logic        za, na, zb, nb, fa, no, zr, ng;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  preset_alu i_preset_alu (
    .a_i(a), .b_i(b), .clr_a_i(za), .neg_a_i(na), .clr_b_i(zb),
    .neg_b_i(nb), .use_add_i(fa), .neg_out_i(no),
    .result_o(res), .is_zero_o(zr), .is_neg_o(ng)
  );

  // {ctrl[5:0], expected[15:0]} with a=16'h0011, b=16'h0003
  localparam logic [21:0] VEC [15] = '{
    {6'b101010, 16'h0000}, {6'b111111, 16'h0001}, {6'b111010, 16'hFFFF},
    {6'b001100, 16'h0011}, {6'b110000, 16'h0003}, {6'b001101, 16'hFFEE},
    {6'b001111, 16'hFFEF}, {6'b011111, 16'h0012}, {6'b000010, 16'h0014},
    {6'b010011, 16'h000E}, {6'b000111, 16'hFFF2}, {6'b000000, 16'h0001},
    {6'b010101, 16'h0013}, {6'b110111, 16'h0004}, {6'b001110, 16'h0010}
  };

  task automatic drive(input logic [5:0] c, input logic [15:0] x, input logic [15:0] y);
    {za, na, zb, nb, fa, no} = c;
    a = x;
    b = y;
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] er, input logic ez, input logic en);
    checks++;
    if (res !== er || zr !== ez || ng !== en) begin
      failures++;
      $display("FAIL %s: got res=%h zr=%b ng=%b, expected res=%h zr=%b ng=%b",
               req, res, zr, ng, er, ez, en);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    drive(6'b000000, 16'h0000, 16'h0000);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8 initial", 16'h0000, 1'b1, 1'b0);

    // table walk, flags from R8/R9
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      drive(VEC[i][21:16], 16'h0011, 16'h0003);
      check("R5/R6/R7/R8/R9 table", VEC[i][15:0], VEC[i][15:0] == 16'h0, VEC[i][15]);
    end

    @(negedge clk);
    drive(6'b101100, 16'h1234, 16'hABCD); check("R1 clear a", 16'h0000, 1'b1, 1'b0);
    drive(6'b101100, 16'hFFFF, 16'hABCD); check("R1 a ignored", 16'h0000, 1'b1, 1'b0);
    drive(6'b111100, 16'h1234, 16'h0000); check("R2 clear then inv", 16'hFFFF, 1'b0, 1'b1);
    drive(6'b010000, 16'h00F0, 16'h0FFF); check("R2 inv only", 16'h0F0F, 1'b0, 1'b0);
    drive(6'b001000, 16'hFFFF, 16'h5555); check("R3 clear b", 16'h0000, 1'b1, 1'b0);
    drive(6'b111100, 16'h0000, 16'h5555); check("R4 clear then inv b", 16'hFFFF, 1'b0, 1'b1);
    drive(6'b000100, 16'hF0F0, 16'h00FF); check("R4 inv b", 16'hF000, 1'b0, 1'b1);
    drive(6'b000010, 16'hFFFF, 16'h0001); check("R5 carry dropped", 16'h0000, 1'b1, 1'b0);
    drive(6'b000010, 16'h8000, 16'h8000); check("R5 top carry", 16'h0000, 1'b1, 1'b0);
    drive(6'b000000, 16'hA5A5, 16'h0FF0); check("R6 and", 16'h05A0, 1'b0, 1'b0);
    drive(6'b000001, 16'hA5A5, 16'h0FF0); check("R7 nand", 16'hFA5F, 1'b0, 1'b1);
    drive(6'b010011, 16'd5, 16'd3);       check("R10 greater", 16'd2, 1'b0, 1'b0);
    drive(6'b010011, 16'h0777, 16'h0777); check("R10 equal", 16'h0000, 1'b1, 1'b0);
    drive(6'b010011, 16'd3, 16'd5);       check("R10 less", 16'hFFFE, 1'b0, 1'b1);
    drive(6'b010011, 16'h7FFF, 16'h8000); check("R11 overflow high", 16'hFFFF, 1'b0, 1'b1);
    drive(6'b010011, 16'h8000, 16'h0001); check("R11 overflow low", 16'h7FFF, 1'b0, 1'b0);

    // R12: change inputs between clock edges, no edge in between
    @(posedge clk); #2;
    drive(6'b000010, 16'h0100, 16'h0020);
    check("R12 no clock", 16'h0120, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule